// File: doc/BRIEF.md
# Masked Pin-Change Interrupt Grouper

This block watches a bank of general input pins, organised as groups of eight, and raises one sticky interrupt flag per group when any enabled pin in that group changes level. Each pin has its own enable bit. A pin whose enable bit is 0 takes no part in its group's detection. A toggle in either direction counts, and the block reacts whether the pin is driven from outside or by the chip itself as an output.

Each pin passes through a transparent latch and then a synchronising flop. A change term is formed per pin from the current and previous synchronised values and gated by that pin's enable bit. The change terms of a group are OR-combined, passed through one more register stage, and then set the group flag. Software clears a flag with a one-cycle clear strobe. A separate combinational wake output compares each enabled pin with its last synchronised value. It does not need a running clock, so a stopped clock can be restarted on a pin change.

Top module: `pinChangeGrouper`

## Requirements
- R1: While reset is asserted, and at the first clock after it is released, every group flag is 0. With all pins at 0, the wake output is also 0.
- R2: Pins 7..0 drive flag bit 0, pins 15..8 drive flag bit 1 and pins 23..16 drive flag bit 2. Pin i has enable bit i of the 24-bit enable input. A change on a pin never sets the flag of another group.
- R3: A rising toggle on an enabled pin sets its group flag, and so does a falling toggle.
- R4: A toggle on a pin whose enable bit is 0 never sets a flag.
- R5: Let a pin change be stable before rising clock edge E1. The flag is still 0 after E1 and after E2, and it reads 1 after E3.
- R6: A flag stays at 1 until it is cleared. A clear strobe (flag-clear bit g at 1 across one rising edge) returns flag g to 0 after that edge.
- R7: If a flag set and a clear strobe for the same group land on the same edge, the flag ends at 1.
- R8: Changing enable bits while the pins are steady sets no flag. A toggle that happens while its pin is disabled is not reported when the pin is enabled later.
- R9: The wake output is 1 whenever an enabled pin differs from its last synchronised value. It reacts combinationally, also while the clock is stopped, and a disabled pin does not raise it.
- R10: Two or more enabled pins of one group that toggle in the same cycle set that group's flag. The changes are OR-combined, so an even number of toggles does not cancel out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | 24 | Pin levels, group g uses bits 8g+7..8g |
| maskIn | input | 24 | Per-pin enable, bit i enables pin i |
| flagClr | input | 3 | Per-group clear strobe |
| groupFlag | output | 3 | Sticky per-group change flags |
| wakeOut | output | 1 | Asynchronous wake on any enabled pin change |

## Verification
Single-pin toggles in each group, in both directions, check the group mapping and show that rising and falling changes are treated alike. A pin toggled against a zero enable bit, enable bits flipped over steady pins, and a pin enabled after its toggle together show that the mask acts on the change and not on the pin level. Two pins of one group toggled on the same edge separate an OR reduction from an XOR reduction. Clears timed to meet a set on the same edge, a stopped clock with enabled and disabled toggles, and a long random mix of toggles, enable changes and clears are all checked against a cycle model kept in the bench.

// File: rtl/pcgPkg.sv
package pcgPkg;
  // per-group command from control to the flag bank
  typedef struct packed {
    logic set;   // a masked change reached the flag stage
    logic hold;  // keep the current flag value (0 means clear)
  } flagCmd_t;
endpackage

// File: rtl/pcgControl.sv
module pcgControl
  import pcgPkg::*;
#(
  parameter int NUM_GROUPS = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_GROUPS-1:0]             groupHit,
  input  logic [NUM_GROUPS-1:0]             flagClr,
  output flagCmd_t [NUM_GROUPS-1:0]         cmd
);

  // extra sync stage between the group OR and the flag
  logic [NUM_GROUPS-1:0] hitSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hitSync <= '0;
    else       hitSync <= groupHit;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gCmd
    assign cmd[g].set  = hitSync[g];
    assign cmd[g].hold = ~flagClr[g];
  end

endmodule

// File: rtl/pcgDatapath.sv
module pcgDatapath
  import pcgPkg::*;
#(
  parameter int NUM_GROUPS  = 3,
  parameter int GROUP_WIDTH = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] pinIn,
  input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] maskIn,
  input  flagCmd_t [NUM_GROUPS-1:0]         cmd,
  output logic [NUM_GROUPS-1:0]             groupHit,
  output logic [NUM_GROUPS-1:0]             groupFlag,
  output logic                              wakeOut
);

  localparam int NumPins = NUM_GROUPS * GROUP_WIDTH;

  logic [NumPins-1:0] pinLat;
  logic [NumPins-1:0] pinSync;
  logic [NumPins-1:0] pinPrev;
  logic [NumPins-1:0] pinChange;
  logic [1:0]         primed;

  // transparent while the clock is low, holds during the high phase
  always_latch begin
    if (!clk) pinLat = pinIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinSync <= '0;
      pinPrev <= '0;
      primed  <= '0;
    end else begin
      pinSync <= pinLat;
      pinPrev <= pinSync;
      primed  <= {primed[0], 1'b1};
    end
  end

  // mask the change term, not the level
  assign pinChange = (pinSync ^ pinPrev) & maskIn;

  // asynchronous wake: enabled pin differs from its captured value
  assign wakeOut = |((pinIn ^ pinSync) & maskIn);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    assign groupHit[g] = primed[1] & (|pinChange[g*GROUP_WIDTH +: GROUP_WIDTH]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) groupFlag[g] <= 1'b0;
      else       groupFlag[g] <= cmd[g].set | (groupFlag[g] & cmd[g].hold);
    end

    assert_hit_to_set_R5: assert property (@(posedge clk) disable iff (!rstN)
      groupHit[g] |=> cmd[g].set);
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
      cmd[g].set |=> groupFlag[g]);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
      (groupFlag[g] && cmd[g].hold) |=> groupFlag[g]);
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
      (!cmd[g].set && !cmd[g].hold) |=> !groupFlag[g]);
    assert_rise_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(groupFlag[g]) |-> $past(cmd[g].set));
  end

endmodule

// File: rtl/pinChangeGrouper.sv
module pinChangeGrouper
  import pcgPkg::*;
#(
  parameter int NUM_GROUPS  = 3,
  parameter int GROUP_WIDTH = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] pinIn,
  input  logic [NUM_GROUPS*GROUP_WIDTH-1:0] maskIn,
  input  logic [NUM_GROUPS-1:0]             flagClr,
  output logic [NUM_GROUPS-1:0]             groupFlag,
  output logic                              wakeOut
);

  flagCmd_t [NUM_GROUPS-1:0] cmd;
  logic [NUM_GROUPS-1:0]     groupHit;

  pcgDatapath #(.NUM_GROUPS(NUM_GROUPS), .GROUP_WIDTH(GROUP_WIDTH)) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .pinIn     (pinIn),
    .maskIn    (maskIn),
    .cmd       (cmd),
    .groupHit  (groupHit),
    .groupFlag (groupFlag),
    .wakeOut   (wakeOut)
  );

  pcgControl #(.NUM_GROUPS(NUM_GROUPS)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .groupHit (groupHit),
    .flagClr  (flagClr),
    .cmd      (cmd)
  );

endmodule

// File: tb/pinChangeGrouper_tb.sv
`timescale 1ns/1ps
module pinChangeGrouper_tb;

  logic        clk = 1'b0;
  logic        clkRun = 1'b1;
  logic        rstN = 1'b0;
  logic [23:0] pinIn = '0;
  logic [23:0] maskIn = '0;
  logic [2:0]  flagClr = '0;
  logic [2:0]  groupFlag;
  logic        wakeOut;

  int checks = 0;
  int errors = 0;

  pinChangeGrouper u_dut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .maskIn(maskIn),
    .flagClr(flagClr), .groupFlag(groupFlag), .wakeOut(wakeOut)
  );

  always #2.5 if (clkRun) clk = ~clk;

  // cycle model built from the requirements
  logic [23:0] mSync, mPrev;
  logic [2:0]  mHit, mFlag;

  function automatic logic [2:0] grpOr(input logic [23:0] v);
    logic [2:0] r;
    for (int g = 0; g < 3; g++) r[g] = |v[g*8 +: 8];
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSync <= '0; mPrev <= '0; mHit <= '0; mFlag <= '0;
    end else begin
      mSync <= pinIn;
      mPrev <= mSync;
      mHit  <= grpOr((mSync ^ mPrev) & maskIn);
      mFlag <= mHit | (mFlag & ~flagClr);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock, then compare at the falling edge
  task automatic step(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req, {29'd0, groupFlag}, {29'd0, mFlag});
  endtask

  task automatic steps(input int n, input string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic clearAll();
    flagClr = 3'b111;
    step("R6");
    flagClr = 3'b000;
    check("R6", {29'd0, groupFlag}, 32'd0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1", {29'd0, groupFlag}, 32'd0);
    check("R1", {31'd0, wakeOut}, 32'd0);
    rstN = 1'b1;
    step("R1");
    check("R1", {29'd0, groupFlag}, 32'd0);
    steps(3, "R1");
    maskIn = 24'hFFFFFF;
    step("R8");

    // R5 latency and R3 rising toggle
    pinIn[0] = 1'b1;
    step("R5"); check("R5", {31'd0, groupFlag[0]}, 32'd0);
    step("R5"); check("R5", {31'd0, groupFlag[0]}, 32'd0);
    step("R5"); check("R5", {31'd0, groupFlag[0]}, 32'd1);
    clearAll();
    // R3 falling toggle
    pinIn[0] = 1'b0;
    steps(3, "R3");
    check("R3", {29'd0, groupFlag}, 32'd1);
    clearAll();

    // R2 group mapping
    for (int g = 0; g < 3; g++) begin
      pinIn[g*8+5] = ~pinIn[g*8+5];
      steps(4, "R2");
      check("R2", {29'd0, groupFlag}, 32'd1 << g);
      clearAll();
    end

    // R6 sticky then clear
    pinIn[12] = ~pinIn[12];
    steps(8, "R6");
    check("R6", {29'd0, groupFlag}, 32'd2);
    flagClr = 3'b010;
    step("R6");
    flagClr = 3'b000;
    check("R6", {29'd0, groupFlag}, 32'd0);

    // R7 set and clear on the same edge
    pinIn[20] = ~pinIn[20];
    step("R7"); step("R7");
    flagClr = 3'b100;
    step("R7");
    check("R7", {29'd0, groupFlag}, 32'd4);
    flagClr = 3'b000;
    clearAll();

    // R10 two pins of one group toggle together
    pinIn[9:8] = ~pinIn[9:8];
    steps(4, "R10");
    check("R10", {29'd0, groupFlag}, 32'd2);
    clearAll();

    // R8 enable flips over steady pins
    for (int i = 0; i < 6; i++) begin
      maskIn = ~maskIn;
      step("R8");
    end
    check("R8", {29'd0, groupFlag}, 32'd0);
    // R4 toggle while disabled, then R8 enable afterwards
    maskIn = 24'hFFFFFF;
    maskIn[3] = 1'b0;
    step("R4");
    pinIn[3] = ~pinIn[3];
    steps(4, "R4");
    check("R4", {29'd0, groupFlag}, 32'd0);
    maskIn[3] = 1'b1;
    steps(4, "R8");
    check("R8", {29'd0, groupFlag}, 32'd0);

    // R9 wake with the clock stopped (clock is low here)
    clkRun = 1'b0;
    maskIn[17] = 1'b0;
    pinIn[17] = ~pinIn[17];
    #20;
    check("R9", {31'd0, wakeOut}, 32'd0);
    maskIn[18] = 1'b1;
    pinIn[18] = ~pinIn[18];
    #20;
    check("R9", {31'd0, wakeOut}, 32'd1);
    check("R9", {29'd0, groupFlag}, 32'd0);
    #20;
    clkRun = 1'b1;
    maskIn[17] = 1'b1;
    steps(4, "R9");
    check("R9", {29'd0, groupFlag}, 32'd4);
    check("R9", {31'd0, wakeOut}, 32'd0);
    clearAll();

    // random mix
    for (int n = 0; n < 2000; n++) begin
      pinIn = pinIn ^ ($urandom & $urandom & $urandom & $urandom);
      if (($urandom % 8) == 0) maskIn = $urandom;
      flagClr = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      #1;
      check("R9", {31'd0, wakeOut}, {31'd0, |((pinIn ^ mSync) & maskIn)});
      step("R3");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule